// File: doc/BRIEF.md
# Dual-Mode External Memory Bus Sequencer

This block runs the external memory bus cycles for a processor with a 20-bit address and an 8-bit data path. It handles three kinds of access: a code fetch, a data read and a data write. Each kind has its own active-low strobe pin. A static mode input chooses one of two pin layouts:

- **Split layout.** The whole address sits on dedicated pins, and the data pins carry data only.
- **Shared layout.** The low address byte is first put on the data pins. An address-latch pulse lets an external register capture it. The upper twelve address bits stay on dedicated pins in both layouts.

One clock period of this block is one half-cycle of the processor bus. Every timing figure below is counted in clock cycles ("ticks").

The processor side uses a simple handshake. A request carries a kind, an address and write data. It is answered by a one-cycle acknowledge, with read data for read-type accesses.

A fetch can be served from on-chip code memory instead of the bus. This happens when it falls below a parameterised boundary and the force-external input is high. Such a fetch is acknowledged at once with a "local" flag and causes no pin activity.

An external wait input stretches data reads and writes. It has no effect on code fetches.

Top module: `ext_bus_ctrl`

## Requirements
- R1: While reset is asserted and after its release, all three strobes are high, the latch pulse is low, the data pins are not driven and the acknowledge is low.
- R2: With `sep_mode` high, no latch pulse is produced. The full address is on `addr_hi` and `addr_lo` from the tick before the strobe falls until the strobe ends. Without wait, `cpu_ack` rises on the fourth edge after the accepting edge.
- R3: With `sep_mode` low, the latch pulse is high for exactly 2 ticks. During those ticks the data pins drive the address bits 7:0. `addr_hi` carries bits 19:8, `addr_lo` stays 0, and no strobe is active while the latch pulse is high.
- R4: With `sep_mode` low, exactly one tick separates the fall of the latch pulse from the strobe. Without wait, `cpu_ack` rises on the sixth edge after the accepting edge.
- R5: `cpu_kind` selects the strobe. The value 00 gives a code fetch on `fetch_stb_n`. The value 01 gives a data read on `read_stb_n`. The values 10 and 11 give a data write on `write_stb_n`. At most one strobe is low at any time. Without wait, the strobe is low for 2 ticks.
- R6: For data reads and writes, `wait_req` is sampled at the end of the first strobe tick. Each time it is sampled high, the strobe is lengthened by one tick.
- R7: A code fetch ignores `wait_req`. Its strobe is always 2 ticks long.
- R8: For a write, the data pins drive `cpu_wdata` from the tick before the strobe falls, through the strobe, and for one tick after the strobe rises, without changing when the strobe rises.
- R9: For reads and external fetches, the data pins are not driven while the strobe is low. `pad_in` is captured in the final strobe tick and returned on `cpu_rdata` together with the acknowledge.
- R10: A fetch is local when `force_ext_n` is high and the address is below `LOCAL_BYTES` (0x20000 by default). A local fetch is acknowledged on the accepting edge with `cpu_local` high and no strobe or latch activity. With `force_ext_n` low, every fetch goes to the bus.
- R11: `cpu_ack` is a single-cycle pulse. `cpu_local` is low for every access that uses the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, one period per half-cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| sep_mode | input | 1 | 1 = split address/data pins, 0 = shared pins with latch pulse |
| force_ext_n | input | 1 | Low sends every fetch to the external bus |
| cpu_req | input | 1 | Access request, held until acknowledged |
| cpu_kind | input | 2 | 00 fetch, 01 read, 1x write |
| cpu_addr | input | 20 | Access address |
| cpu_wdata | input | 8 | Write data |
| cpu_ack | output | 1 | One-cycle completion pulse |
| cpu_local | output | 1 | Fetch served on chip, with the acknowledge |
| cpu_rdata | output | 8 | Captured read data |
| addr_hi | output | 12 | Address bits 19:8 |
| addr_lo | output | 8 | Address bits 7:0 in split layout, else 0 |
| alatch | output | 1 | Address-latch pulse, shared layout |
| fetch_stb_n | output | 1 | Code fetch strobe, active low |
| read_stb_n | output | 1 | Data read strobe, active low |
| write_stb_n | output | 1 | Data write strobe, active low |
| wait_req | input | 1 | Stretch request for data accesses |
| pad_in | input | 8 | Data pin input value |
| pad_out | output | 8 | Data pin output value |
| pad_oe | output | 1 | Data pin output enable |

## Verification
The embedded properties check the following on every cycle:
- strobe exclusivity;
- the absence of strobes during the latch pulse;
- the absence of a latch pulse in split layout;
- pin drive during writes and release during reads;
- write data held steady across the strobe's rising edge;
- the sequencer's entry order;
- the single-cycle acknowledge.

Only the bench scenarios can show the following:
- the cycle counts of whole accesses and the exact lengths of the strobe and latch pulse;
- the wait stretch, and wait being ignored on fetches;
- the address values presented on the pins;
- the read data returned;
- the boundary of the on-chip fetch window under both settings of the force-external input.

// File: rtl/ebc_pkg.sv
package ebc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ALAT = 3'd1,
    ST_LEAD = 3'd2,
    ST_STRB = 3'd3,
    ST_TAIL = 3'd4
  } ebc_state_e;

  localparam logic [1:0] KIND_FETCH = 2'b00;
  localparam logic [1:0] KIND_READ  = 2'b01;

  function automatic logic kind_is_write(input logic [1:0] k);
    return k[1];
  endfunction

endpackage

// File: rtl/ebc_seq.sv
module ebc_seq
  import ebc_pkg::*;
#(
  parameter int ALE_TICKS = 2,
  parameter int STB_TICKS = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       sep_mode,
  input  logic       wait_ok,
  input  logic       wait_req,
  output ebc_state_e state_q,
  output ebc_state_e state_d,
  output logic       cap_now
);

  localparam int MAXT  = (ALE_TICKS > STB_TICKS) ? ALE_TICKS : STB_TICKS;
  localparam int CNT_W = $clog2(MAXT + 1);

  localparam logic [CNT_W-1:0] ALE_LAST = CNT_W'(ALE_TICKS - 1);
  localparam logic [CNT_W-1:0] STB_LAST = CNT_W'(STB_TICKS - 1);
  localparam logic [CNT_W-1:0] STB_WPT  = CNT_W'(STB_TICKS - 2);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          cnt_d   = '0;
          state_d = sep_mode ? ST_LEAD : ST_ALAT;
        end
      end
      ST_ALAT: begin
        if (cnt_q == ALE_LAST) begin
          cnt_d   = '0;
          state_d = ST_LEAD;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_LEAD: begin
        cnt_d   = '0;
        state_d = ST_STRB;
      end
      ST_STRB: begin
        if (cnt_q == STB_LAST) begin
          cnt_d   = '0;
          state_d = ST_TAIL;
        end else if (!(cnt_q == STB_WPT && wait_ok && wait_req)) begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_TAIL: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  assign cap_now = (state_q == ST_STRB) && (cnt_q == STB_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  AST_ALAT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ALAT) |-> (cnt_q <= ALE_LAST)); // R3
  AST_STRB_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_STRB && $past(state_q) != ST_STRB) |-> ($past(state_q) == ST_LEAD)); // R4
  AST_SPLIT_NO_ALAT: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_q) == ST_IDLE && state_q != ST_IDLE && sep_mode) |-> (state_q == ST_LEAD)); // R2

endmodule

// File: rtl/ebc_pins.sv
module ebc_pins
  import ebc_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sep_mode,
  input  ebc_state_e               state_d,
  input  logic [1:0]               kind_n,
  input  logic [ADDR_W-1:0]        addr_n,
  input  logic [DATA_W-1:0]        wdata_n,
  output logic [ADDR_W-DATA_W-1:0] addr_hi,
  output logic [DATA_W-1:0]        addr_lo,
  output logic                     alatch,
  output logic                     fetch_stb_n,
  output logic                     read_stb_n,
  output logic                     write_stb_n,
  output logic [DATA_W-1:0]        pad_out,
  output logic                     pad_oe
);

  localparam int HI_W = ADDR_W - DATA_W;

  logic [HI_W-1:0]   hi_d;
  logic [DATA_W-1:0] lo_d, out_d;
  logic              al_d, fs_d, rs_d, ws_d, oe_d;
  logic              stb, wr_phase;

  always_comb begin
    hi_d = addr_hi;
    lo_d = addr_lo;
    if (state_d != ST_IDLE) begin
      hi_d = addr_n[ADDR_W-1:DATA_W];
      lo_d = sep_mode ? addr_n[DATA_W-1:0] : '0;
    end
    al_d     = (state_d == ST_ALAT);
    stb      = (state_d == ST_STRB);
    fs_d     = !(stb && kind_n == KIND_FETCH);
    rs_d     = !(stb && kind_n == KIND_READ);
    ws_d     = !(stb && kind_is_write(kind_n));
    wr_phase = kind_is_write(kind_n) &&
               (state_d == ST_LEAD || state_d == ST_STRB || state_d == ST_TAIL);
    if (al_d) begin
      oe_d  = 1'b1;
      out_d = addr_n[DATA_W-1:0];
    end else if (wr_phase) begin
      oe_d  = 1'b1;
      out_d = wdata_n;
    end else begin
      oe_d  = 1'b0;
      out_d = pad_out;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_hi     <= '0;
      addr_lo     <= '0;
      alatch      <= 1'b0;
      fetch_stb_n <= 1'b1;
      read_stb_n  <= 1'b1;
      write_stb_n <= 1'b1;
      pad_out     <= '0;
      pad_oe      <= 1'b0;
    end else begin
      addr_hi     <= hi_d;
      addr_lo     <= lo_d;
      alatch      <= al_d;
      fetch_stb_n <= fs_d;
      read_stb_n  <= rs_d;
      write_stb_n <= ws_d;
      pad_out     <= out_d;
      pad_oe      <= oe_d;
    end
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({!fetch_stb_n, !read_stb_n, !write_stb_n}) <= 1); // R5
  AST_NO_STB_IN_ALAT: assert property (@(posedge clk) disable iff (!rst_n)
    alatch |-> (fetch_stb_n && read_stb_n && write_stb_n)); // R3
  AST_SPLIT_NO_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (sep_mode && $stable(sep_mode)) |-> !alatch); // R2
  AST_WR_DRIVES_PAD: assert property (@(posedge clk) disable iff (!rst_n)
    !write_stb_n |-> pad_oe); // R8
  AST_WR_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(write_stb_n) |-> (pad_oe && $stable(pad_out))); // R8
  AST_RD_PAD_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
    (!read_stb_n || !fetch_stb_n) |-> !pad_oe); // R9

endmodule

// File: rtl/ext_bus_ctrl.sv
module ext_bus_ctrl
  import ebc_pkg::*;
#(
  parameter int          ADDR_W      = 20,
  parameter int          DATA_W      = 8,
  parameter int unsigned LOCAL_BYTES = 131072,
  parameter int          ALE_TICKS   = 2,
  parameter int          STB_TICKS   = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sep_mode,
  input  logic                     force_ext_n,
  input  logic                     cpu_req,
  input  logic [1:0]               cpu_kind,
  input  logic [ADDR_W-1:0]        cpu_addr,
  input  logic [DATA_W-1:0]        cpu_wdata,
  output logic                     cpu_ack,
  output logic                     cpu_local,
  output logic [DATA_W-1:0]        cpu_rdata,
  output logic [ADDR_W-DATA_W-1:0] addr_hi,
  output logic [DATA_W-1:0]        addr_lo,
  output logic                     alatch,
  output logic                     fetch_stb_n,
  output logic                     read_stb_n,
  output logic                     write_stb_n,
  input  logic                     wait_req,
  input  logic [DATA_W-1:0]        pad_in,
  output logic [DATA_W-1:0]        pad_out,
  output logic                     pad_oe
);

  localparam logic [ADDR_W:0] LOCAL_LIM = LOCAL_BYTES[ADDR_W:0];

  logic [1:0]        rst_sync;
  logic              rst_i;
  ebc_state_e        state_q, state_d;
  logic              cap_now, accept, is_local, start, ack_d, local_d;
  logic [1:0]        kind_q, kind_n;
  logic [ADDR_W-1:0] addr_q, addr_n;
  logic [DATA_W-1:0] wdata_q, wdata_n, rdata_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i = rst_sync[1];

  always_comb begin
    accept   = (state_q == ST_IDLE) && cpu_req && !cpu_ack;
    is_local = (cpu_kind == KIND_FETCH) && force_ext_n &&
               ({1'b0, cpu_addr} < LOCAL_LIM);
    start    = accept && !is_local;
    ack_d    = (accept && is_local) || (state_q == ST_TAIL);
    local_d  = accept && is_local;
    kind_n   = accept ? cpu_kind  : kind_q;
    addr_n   = accept ? cpu_addr  : addr_q;
    wdata_n  = accept ? cpu_wdata : wdata_q;
    rdata_d  = cap_now ? pad_in : cpu_rdata;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      kind_q    <= KIND_FETCH;
      addr_q    <= '0;
      wdata_q   <= '0;
      cpu_ack   <= 1'b0;
      cpu_local <= 1'b0;
      cpu_rdata <= '0;
    end else begin
      if (accept) begin
        kind_q  <= cpu_kind;
        addr_q  <= cpu_addr;
        wdata_q <= cpu_wdata;
      end
      cpu_ack   <= ack_d;
      cpu_local <= local_d;
      cpu_rdata <= rdata_d;
    end
  end

  ebc_seq #(.ALE_TICKS(ALE_TICKS), .STB_TICKS(STB_TICKS)) u_seq (
    .clk     (clk),
    .rst_n   (rst_i),
    .start   (start),
    .sep_mode(sep_mode),
    .wait_ok (kind_q != KIND_FETCH),
    .wait_req(wait_req),
    .state_q (state_q),
    .state_d (state_d),
    .cap_now (cap_now)
  );

  ebc_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .clk        (clk),
    .rst_n      (rst_i),
    .sep_mode   (sep_mode),
    .state_d    (state_d),
    .kind_n     (kind_n),
    .addr_n     (addr_n),
    .wdata_n    (wdata_n),
    .addr_hi    (addr_hi),
    .addr_lo    (addr_lo),
    .alatch     (alatch),
    .fetch_stb_n(fetch_stb_n),
    .read_stb_n (read_stb_n),
    .write_stb_n(write_stb_n),
    .pad_out    (pad_out),
    .pad_oe     (pad_oe)
  );

  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_i)
    cpu_ack |=> !cpu_ack); // R11
  AST_LOCAL_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_i)
    cpu_local |-> cpu_ack); // R10
  AST_LOCAL_QUIET: assert property (@(posedge clk) disable iff (!rst_i)
    cpu_local |-> (fetch_stb_n && read_stb_n && write_stb_n && !alatch)); // R10

endmodule

// File: tb/tb_ext_bus_ctrl.sv
module tb_ext_bus_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sep_mode = 1'b1, force_ext_n = 1'b1, cpu_req = 1'b0;
  logic [1:0]  cpu_kind = 2'b00;
  logic [19:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        cpu_ack, cpu_local;
  logic [7:0]  cpu_rdata;
  logic [11:0] addr_hi;
  logic [7:0]  addr_lo;
  logic        alatch, fetch_stb_n, read_stb_n, write_stb_n;
  logic        wait_req = 1'b0;
  logic [7:0]  pad_in = '0;
  logic [7:0]  pad_out;
  logic        pad_oe;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  ext_bus_ctrl dut (
    .clk(clk), .rst_n(rst_n), .sep_mode(sep_mode), .force_ext_n(force_ext_n),
    .cpu_req(cpu_req), .cpu_kind(cpu_kind), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_ack(cpu_ack), .cpu_local(cpu_local), .cpu_rdata(cpu_rdata),
    .addr_hi(addr_hi), .addr_lo(addr_lo), .alatch(alatch),
    .fetch_stb_n(fetch_stb_n), .read_stb_n(read_stb_n), .write_stb_n(write_stb_n),
    .wait_req(wait_req), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  function automatic logic [7:0] memfn(input logic [19:0] a);
    return a[7:0] ^ a[15:8] ^ {a[19:16], 4'h5};
  endfunction

  function automatic int exp_ack_cycle(input bit loc, input bit sep, input int w);
    if (loc) return 1;
    return (sep ? 5 : 7) + w;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_txn(input logic [1:0] kind, input logic [19:0] addr,
                         input logic [7:0] wd, input bit sep, input bit fext_n,
                         input int w);
    bit loc  = (kind == 2'b00) && fext_n && (addr < 20'h20000);
    bit data = (kind != 2'b00);
    bit we   = kind[1];
    int ew   = data ? w : 0;
    int nf = 0, nr = 0, nw = 0, nal = 0, s_first = -1, a_last = -1, ack_n = -1;
    bit pad_al_bad = 0, addr_bad = 0, setup_bad = 0, wd_bad = 0, float_bad = 0;
    bit tail_seen = 0, prev_low = 0, prev_addr_ok = 0, got_local = 0;
    logic [7:0] got_rd = '0;
    @(negedge clk);
    sep_mode = sep; force_ext_n = fext_n;
    cpu_kind = kind; cpu_addr = addr; cpu_wdata = wd; cpu_req = 1'b1;
    wait_req = 1'b0;
    for (int n = 1; n <= 40; n++) begin
      bit low;
      bit aok;
      @(negedge clk);
      cpu_req = 1'b0;
      low = !fetch_stb_n || !read_stb_n || !write_stb_n;
      nf += !fetch_stb_n; nr += !read_stb_n; nw += !write_stb_n;
      aok = (addr_hi == addr[19:8]) && (addr_lo == (sep ? addr[7:0] : 8'h00));
      if (alatch) begin
        nal++; a_last = n;
        if (!(pad_oe && pad_out == addr[7:0])) pad_al_bad = 1;
      end
      if (low) begin
        if (s_first < 0) begin
          s_first = n;
          if (!prev_addr_ok) setup_bad = 1;
        end
        if (!aok) addr_bad = 1;
        if (we && !(pad_oe && pad_out == wd)) wd_bad = 1;
        if (!we && pad_oe) float_bad = 1;
      end else if (prev_low && we) begin
        tail_seen = 1;
        if (!(pad_oe && pad_out == wd)) wd_bad = 1;
      end
      prev_low = low; prev_addr_ok = aok;
      wait_req = low && ((nf + nr + nw) <= w);
      pad_in   = (!read_stb_n || !fetch_stb_n) ? memfn(addr) : ~memfn(addr);
      if (cpu_ack) begin
        ack_n = n; got_local = cpu_local; got_rd = cpu_rdata;
        break;
      end
    end
    wait_req = 1'b0;
    chk(ack_n == exp_ack_cycle(loc, sep, ew), loc ? "R10 ack time" : (sep ? "R2 ack time" : "R4 ack time"),
        ack_n, exp_ack_cycle(loc, sep, ew));
    chk(nf == ((!loc && kind == 2'b00) ? 2 : 0), "R7 fetch strobe length", nf,
        (!loc && kind == 2'b00) ? 2 : 0);
    chk(nr == (kind == 2'b01 ? 2 + ew : 0), "R6 read strobe length", nr, kind == 2'b01 ? 2 + ew : 0);
    chk(nw == (we ? 2 + ew : 0), "R5 write strobe length", nw, we ? 2 + ew : 0);
    chk(nal == ((loc || sep) ? 0 : 2), "R3 latch pulse ticks", nal, (loc || sep) ? 0 : 2);
    chk(got_local == loc, "R11 local flag", got_local, loc);
    if (!loc) begin
      chk(!pad_al_bad, "R3 low address on pads", pad_al_bad, 0);
      chk(!addr_bad, "R2 address pins during strobe", addr_bad, 0);
      if (sep) chk(!setup_bad, "R2 address before strobe", setup_bad, 0);
      else     chk(s_first - a_last == 2, "R4 latch-to-strobe gap", s_first - a_last, 2);
      if (we) begin
        chk(!wd_bad, "R8 write data on pads", wd_bad, 0);
        chk(tail_seen, "R8 hold tick after strobe", tail_seen, 1);
      end else begin
        chk(!float_bad, "R9 pads released", float_bad, 0);
        chk(got_rd == memfn(addr), "R9 read data", got_rd, memfn(addr));
      end
    end
    @(negedge clk);
    chk(!cpu_ack, "R11 ack single pulse", cpu_ack, 0);
  endtask

  initial begin
    int unsigned sd = $urandom(32'd20240611);
    sd = 0;
    repeat (3) @(negedge clk);
    chk(fetch_stb_n && read_stb_n && write_stb_n, "R1 strobes in reset",
        {fetch_stb_n, read_stb_n, write_stb_n}, 7);
    chk(!alatch && !pad_oe && !cpu_ack, "R1 latch/pads/ack in reset",
        {alatch, pad_oe, cpu_ack}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(fetch_stb_n && read_stb_n && write_stb_n && !alatch && !pad_oe && !cpu_ack,
        "R1 idle after reset", {fetch_stb_n, read_stb_n, write_stb_n, alatch, pad_oe, cpu_ack}, 56);

    run_txn(2'b01, 20'hA5C3E, 8'h00, 1'b1, 1'b1, 0);   // R2 split read
    run_txn(2'b10, 20'h3F012, 8'h96, 1'b0, 1'b1, 0);   // R3 R8 shared write
    run_txn(2'b01, 20'h7ABCD, 8'h00, 1'b0, 1'b1, 3);   // R6 shared read, wait
    run_txn(2'b11, 20'h44455, 8'h5A, 1'b1, 1'b1, 2);   // R5 kind 11, R6
    run_txn(2'b00, 20'hC0001, 8'h00, 1'b1, 1'b1, 3);   // R7 fetch ignores wait
    run_txn(2'b00, 20'h1FFFF, 8'h00, 1'b0, 1'b1, 0);   // R10 local boundary
    run_txn(2'b00, 20'h20000, 8'h00, 1'b0, 1'b1, 0);   // R10 first external
    run_txn(2'b00, 20'h00010, 8'h00, 1'b1, 1'b0, 0);   // R10 forced external

    for (int i = 0; i < 300; i++) begin
      logic [1:0]  k  = 2'($urandom_range(0, 3));
      logic [19:0] a  = 20'($urandom);
      if ($urandom_range(0, 3) == 0) a[19:17] = 3'b000;
      run_txn(k, a, 8'($urandom), 1'($urandom), 1'($urandom), $urandom_range(0, 4));
    end

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule